// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a synchronous request port and one external 32K x 8 asynchronous static RAM that shares a single 8-bit data bus for reads and writes. A request carries a write flag, a 15-bit word address and, for writes, a data byte. The controller turns each accepted request into the active-low select, output-enable and write-strobe sequence the memory needs. It places the address, and it enables its own bus drivers only while it is writing. For a read it releases the bus, waits out the access time and then returns the byte with a one-cycle valid pulse.

All memory timing minimums are turned into whole clock cycles at elaboration. The clock period parameter is given in picoseconds. A one-bit parameter selects between the 55 ns and 70 ns speed figures. Each minimum is rounded up, so any nonzero figure takes at least one cycle.

A write is controlled by the write strobe. Select goes low together with the write strobe and stays low for one or more cycles after the write strobe rises. When a write follows a read, the bus driver stays off inside the strobe until the memory's float time after output-enable deassertion has passed. The strobe is then stretched so that the data still meets its setup time to the rising edge.

Top module: `asram_port_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, select, output-enable and write strobe are high (1), the bus drive enable is 0, the read-valid output is 0 and the request-ready output is 1.
- R2: A write stores the request byte at the request address, so that a later read of that address returns it; the write strobe is low only while select is low.
- R3: The write strobe stays low for at least ceil(max(WE pulse, address setup to write end) / clock period) cycles, 6 at 8 ns in the fast grade, with the address unchanged for the whole low time.
- R4: The bus drive enable is 1 only while the write strobe is low, and it has been 1 for at least ceil(data setup / clock period) cycles, 4 at 8 ns in the fast grade, when the write strobe rises.
- R5: A read holds select and output-enable low with the write strobe high for at least ceil(max(read cycle, address access, output-enable access) / clock period) cycles, 7 at 8 ns in the fast grade. The sampled byte then appears on the read-data output with a read-valid pulse exactly one cycle wide.
- R6: The bus drive enable is never 1 while output-enable is low, and it is not 1 until output-enable has been high for at least ceil(float time / clock period) cycles, 3 at 8 ns in the fast grade.
- R7: In a write, select is still low in the cycle in which the write strobe rises. Select stays low for at least ceil(write cycle / clock period) cycles in total, 7 at 8 ns in the fast grade.
- R8: Request-ready is 1 only when no operation is in progress. Each accepted request starts exactly one memory operation. Writes produce no read-valid pulse, and each read produces exactly one.
- R9: The lowest address 0x0000 and the highest address 0x7FFF reach distinct memory words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle, request accepted on this edge if valid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 15 | Word address |
| reqWdata | input | 8 | Write byte |
| rdValid | output | 1 | One-cycle pulse: rdData holds read result |
| rdData | output | 8 | Read byte |
| memAddr | output | 15 | Address to the memory |
| memCeN | output | 1 | Active-low chip select |
| memOeN | output | 1 | Active-low output enable |
| memWeN | output | 1 | Active-low write strobe |
| memDqOut | output | 8 | Byte driven onto the shared bus |
| memDqOe | output | 1 | Tri-state enable for the shared bus |
| memDqIn | input | 8 | Byte seen on the shared bus |

## Verification
The assertions check on every cycle the timing rules that can be stated as properties of the strobes. These are the float gap counted from output-enable rising before the bus driver turns on, the minimum write strobe width, select still low when the write strobe rises, the address held steady under the strobe, the single-cycle read-valid pulse and ready falling after acceptance. Only the bench scenarios can show that bytes actually land at the right addresses and come back intact, including at both ends of the address range. They also show how a write behaves right after a read, where the strobe must stretch, and how a stream of mixed requests is ordered end to end.

// File: rtl/asram_pkg.sv
package asram_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic ceN;
    logic oeN;
    logic weN;
    logic drive;
    logic load;
    logic capture;
  } strobe_t;

  // Round a time in picoseconds up to whole clock cycles
  function automatic int psToCycles(input int timePs, input int clkPs);
    if (timePs <= 0) return 0;
    return (timePs + clkPs - 1) / clkPs;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_ctl.sv
module asram_ctl
  import asram_pkg::*;
#(
  parameter int WP_CYC  = 6,
  parameter int DS_CYC  = 4,
  parameter int WC_CYC  = 7,
  parameter int RD_CYC  = 7,
  parameter int FLT_CYC = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output strobe_t stb
);

  localparam int CNT_W = $clog2(WP_CYC + DS_CYC + WC_CYC + RD_CYC + FLT_CYC + 2);

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WPULSE, ST_WTAIL} state_t;

  state_t             state;
  logic [CNT_W-1:0]   phaseCnt;
  logic [CNT_W-1:0]   setupCnt;
  logic [CNT_W-1:0]   floatCnt;
  logic               lastRead;
  logic               pulseDone;

  always_comb begin
    stb.ceN     = (state == ST_IDLE);
    stb.oeN     = (state != ST_READ);
    stb.weN     = (state != ST_WPULSE);
    stb.drive   = (state == ST_WPULSE) && (floatCnt == '0);
    stb.load    = (state == ST_IDLE) && reqValid;
    lastRead    = (state == ST_READ) && (int'(phaseCnt) == RD_CYC - 1);
    stb.capture = lastRead;
    pulseDone   = stb.drive
                  && (int'(phaseCnt) + 1 >= WP_CYC)
                  && (int'(setupCnt) + 1 >= DS_CYC);
  end

  assign reqReady = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      setupCnt <= '0;
      floatCnt <= '0;
    end else begin
      if (lastRead)              floatCnt <= CNT_W'(FLT_CYC);
      else if (floatCnt != '0)   floatCnt <= floatCnt - 1'b1;

      case (state)
        ST_IDLE: begin
          phaseCnt <= '0;
          setupCnt <= '0;
          if (reqValid) state <= reqWrite ? ST_WPULSE : ST_READ;
        end
        ST_READ: begin
          phaseCnt <= phaseCnt + 1'b1;
          if (lastRead) state <= ST_IDLE;
        end
        ST_WPULSE: begin
          phaseCnt <= phaseCnt + 1'b1;
          if (stb.drive) setupCnt <= setupCnt + 1'b1;
          if (pulseDone) state <= ST_WTAIL;
        end
        ST_WTAIL: begin
          phaseCnt <= phaseCnt + 1'b1;
          if (int'(phaseCnt) + 1 >= WC_CYC) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Observation counters for the checks below
  logic [CNT_W-1:0] oeHighCnt;
  logic [CNT_W-1:0] weLowCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oeHighCnt <= '1;
      weLowCnt  <= '0;
    end else begin
      if (!stb.oeN)               oeHighCnt <= '0;
      else if (oeHighCnt != '1)   oeHighCnt <= oeHighCnt + 1'b1;
      if (!stb.weN)               weLowCnt  <= weLowCnt + 1'b1;
      else                        weLowCnt  <= '0;
    end
  end

  // R6
  float_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.drive |-> (int'(oeHighCnt) >= FLT_CYC));

  // R3
  we_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stb.weN) |-> (int'(weLowCnt) >= WP_CYC));

  // R7
  we_end_ce_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stb.weN) |-> !stb.ceN);

  // R8
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> !reqReady);

endmodule

// File: rtl/asram_dp.sv
module asram_dp
  import asram_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      dataQ   <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      if (stb.load) begin
        addrQ <= reqAddr;
        dataQ <= reqWdata;
      end
      if (stb.capture) rdData <= memDqIn;
      rdValid <= stb.capture;
    end
  end

  assign memAddr  = addrQ;
  assign memDqOut = dataQ;
  assign memDqOe  = stb.drive;
  assign memCeN   = stb.ceN;
  assign memOeN   = stb.oeN;
  assign memWeN   = stb.weN;

  // R5
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

endmodule

// File: rtl/asram_port_ctrl.sv
module asram_port_ctrl
  import asram_pkg::*;
#(
  parameter int CLK_PS     = 8000,
  parameter bit FAST_GRADE = 1'b1,
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  // Memory minimums in picoseconds for the selected grade
  localparam int T_WRCYC  = FAST_GRADE ? 55000 : 70000;
  localparam int T_WEPW   = FAST_GRADE ? 40000 : 50000;
  localparam int T_ADSET  = FAST_GRADE ? 45000 : 60000;
  localparam int T_DSET   = FAST_GRADE ? 25000 : 30000;
  localparam int T_RDCYC  = FAST_GRADE ? 55000 : 70000;
  localparam int T_ACC    = FAST_GRADE ? 55000 : 70000;
  localparam int T_OEACC  = FAST_GRADE ? 25000 : 35000;
  localparam int T_FLOAT  = FAST_GRADE ? 20000 : 25000;

  localparam int WP_CYC  = maxOf(psToCycles(T_WEPW, CLK_PS), psToCycles(T_ADSET, CLK_PS));
  localparam int DS_CYC  = psToCycles(T_DSET, CLK_PS);
  localparam int WC_CYC  = psToCycles(T_WRCYC, CLK_PS);
  localparam int RD_CYC  = maxOf(maxOf(psToCycles(T_RDCYC, CLK_PS), psToCycles(T_ACC, CLK_PS)),
                                 psToCycles(T_OEACC, CLK_PS));
  localparam int FLT_CYC = psToCycles(T_FLOAT, CLK_PS);

  strobe_t stb;

  asram_ctl #(
    .WP_CYC (WP_CYC),
    .DS_CYC (DS_CYC),
    .WC_CYC (WC_CYC),
    .RD_CYC (RD_CYC),
    .FLT_CYC(FLT_CYC)
  ) u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .stb     (stb)
  );

  asram_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .rdValid (rdValid),
    .rdData  (rdData),
    .memAddr (memAddr),
    .memCeN  (memCeN),
    .memOeN  (memOeN),
    .memWeN  (memWeN),
    .memDqOut(memDqOut),
    .memDqOe (memDqOe),
    .memDqIn (memDqIn)
  );

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && $past(!memWeN)) |-> $stable(memAddr));

endmodule

// File: tb/tb_asram_port_ctrl.sv
module tb_asram_port_ctrl;

  localparam int CLK_NS  = 8;
  localparam int WE_MIN  = (45 + CLK_NS - 1) / CLK_NS;
  localparam int DS_MIN  = (25 + CLK_NS - 1) / CLK_NS;
  localparam int FLT_MIN = (20 + CLK_NS - 1) / CLK_NS;
  localparam int RD_MIN  = (55 + CLK_NS - 1) / CLK_NS;
  localparam int WC_MIN  = (55 + CLK_NS - 1) / CLK_NS;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [14:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        rdValid;
  logic [7:0]  rdData;
  logic [14:0] memAddr;
  logic        memCeN, memOeN, memWeN;
  logic [7:0]  memDqOut;
  logic        memDqOe;
  logic [7:0]  memDqIn = 8'h00;

  always #4 clk = ~clk;

  asram_port_ctrl #(.CLK_PS(8000), .FAST_GRADE(1'b1)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdValid(rdValid), .rdData(rdData), .memAddr(memAddr),
    .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  int total = 0;
  int bad = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard state
  logic [7:0] shadow [int];
  logic [7:0] expQ [$];

  task automatic doReq(input bit wr, input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    if (wr) shadow[int'(a)] = d;
    else    expQ.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 8'hFF);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // Memory model and protocol monitor
  logic [7:0] mem [int];
  logic       prevWeN = 1'b1, prevCeN = 1'b1, prevOeN = 1'b1, prevDrive = 1'b0, prevRv = 1'b0;
  int         weLow = 0, drvLow = 0, ceLow = 0, oeLow = 0, oeHi = 100;
  logic [14:0] weAddr = '0;
  logic [7:0]  weData = '0;
  bit          ceHadWrite = 0;

  always @(negedge clk) begin
    if (rstN) begin
      // R6: no drive against an enabled memory output, and float gap respected
      if (memDqOe && !memOeN) check(0, "R6 drive with oe low", 1, 0);
      if (memDqOe && !prevDrive) check(oeHi >= FLT_MIN, "R6 float gap", oeHi, FLT_MIN);
      if (!memOeN) oeHi = 0; else oeHi++;

      // R4: drive only under the write strobe
      if (memDqOe && memWeN) check(0, "R4 drive with we high", 1, 0);

      // Write strobe tracking
      if (!memWeN) begin
        if (prevWeN) begin weLow = 0; drvLow = 0; weAddr = memAddr; end
        else if (memAddr != weAddr) check(0, "R3 address moved", int'(memAddr), int'(weAddr));
        if (memCeN) check(0, "R2 we low without ce", 1, 0);
        weLow++;
        if (memDqOe) begin drvLow++; weData = memDqOut; end
        else drvLow = 0;
      end else if (!prevWeN) begin
        check(weLow >= WE_MIN, "R3 we width", weLow, WE_MIN);
        check(drvLow >= DS_MIN, "R4 data setup", drvLow, DS_MIN);
        check(!memCeN, "R7 ce low at we rise", int'(memCeN), 0);
        mem[int'(weAddr)] = weData;
        ceHadWrite = 1;
      end

      // Select tracking
      if (!memCeN) begin
        ceLow++;
        if (reqReady) check(0, "R8 ready while busy", 1, 0);
      end else begin
        if (!prevCeN && ceHadWrite) check(ceLow >= WC_MIN, "R7 write cycle", ceLow, WC_MIN);
        ceLow = 0;
        ceHadWrite = 0;
      end

      // Read tracking
      if (!memOeN) begin
        oeLow++;
        if (memCeN || !memWeN) check(0, "R5 read strobes", {memCeN, memWeN}, 1);
      end else begin
        if (!prevOeN) check(oeLow >= RD_MIN, "R5 read access", oeLow, RD_MIN);
        oeLow = 0;
      end

      // Read data monitor
      if (rdValid) begin
        if (prevRv) check(0, "R5 valid pulse width", 2, 1);
        if (expQ.size() == 0) check(0, "R8 unexpected read valid", 1, 0);
        else begin
          logic [7:0] e;
          e = expQ.pop_front();
          check(rdData == e, "R2 R5 read data", int'(rdData), int'(e));
        end
      end

      prevWeN = memWeN; prevCeN = memCeN; prevOeN = memOeN;
      prevDrive = memDqOe; prevRv = rdValid;

      memDqIn = (!memCeN && !memOeN && memWeN)
                ? (mem.exists(int'(memAddr)) ? mem[int'(memAddr)] : 8'hFF) : 8'h00;
    end
  end

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R8 watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(memCeN && memOeN && memWeN, "R1 strobes in reset", {memCeN, memOeN, memWeN}, 7);
    check(!memDqOe && !rdValid, "R1 drive/valid in reset", {memDqOe, rdValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady, "R1 ready after reset", int'(reqReady), 1);
    check(memCeN && memOeN && memWeN && !memDqOe, "R1 idle strobes", {memCeN, memOeN, memWeN, memDqOe}, 14);

    // R9: both ends of the address range
    doReq(1, 15'h0000, 8'h3C);
    doReq(1, 15'h7FFF, 8'hC3);
    doReq(0, 15'h0000, 8'h00);
    doReq(0, 15'h7FFF, 8'h00);

    // R6: write right after a read stretches the strobe
    doReq(1, 15'h1234, 8'h5A);
    doReq(0, 15'h1234, 8'h00);
    doReq(1, 15'h1234, 8'hA5);
    doReq(0, 15'h1234, 8'h00);

    // R2: overwrite then back-to-back reads
    doReq(1, 15'h0001, 8'h01);
    doReq(1, 15'h0001, 8'hFE);
    doReq(0, 15'h0001, 8'h00);
    doReq(0, 15'h7FFF, 8'h00);
    doReq(0, 15'h0000, 8'h00);

    // Walking address bits with mixed traffic
    for (int i = 0; i < 15; i++) begin
      doReq(1, 15'(1 << i), 8'(8'h10 + i));
    end
    for (int i = 0; i < 15; i++) begin
      doReq(0, 15'(1 << i), 8'h00);
      doReq(1, 15'(15'h4000 >> i) ^ 15'h0F0F, 8'(8'hE0 ^ i));
    end
    for (int i = 0; i < 15; i++) begin
      doReq(0, 15'(15'h4000 >> i) ^ 15'h0F0F, 8'h00);
    end

    repeat (20) @(negedge clk);
    // R8: every read answered once, no extra valids
    check(expQ.size() == 0, "R8 outstanding reads", expQ.size(), 0);
    check(reqReady && memCeN, "R8 idle at end", {reqReady, memCeN}, 3);
    finishRun();
  end

endmodule